// File: doc/BRIEF.md
# Threshold trigger detector

This block decides the moment at which a burst capture is triggered. Every converter result arrives as a 12-bit sample with a one-cycle done strobe. The block takes the eight most significant bits of that sample and compares them with an 8-bit threshold. In bipolar range mode both values are two's complement. In unipolar range mode both are plain binary.

Four comparator conditions are available: a rising crossing, a falling crossing, a level above the threshold and a level below it. An active-low external trigger line can also fire the trigger. That line is synchronised into the clock domain first and is looked at only on sample strobes.

Triggering is possible only in burst mode and only while the active-low arm input is held low. When it fires, the block emits a single-cycle trigger pulse and sets a sticky triggered flag. A run-start pulse clears the flag and the crossing history, ready for the next capture.

Top module: `trig_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `trig_pulse_o` and `triggered_o` are 0.
- R2: The compared value is sample bits [11:4]. With `bipolar_i`=1 the values are ordered as two's complement (for example 0xFF is below 0x00). With `bipolar_i`=0 they are ordered as unsigned (0xFF is above 0x80).
- R3: With `edge_sel_i`=1 and `level_sel_i`=0, a strobed sample above the threshold fires when the previous armed sample was not above it.
- R4: With `edge_sel_i`=0 and `level_sel_i`=0, a strobed sample below the threshold fires when the previous armed sample was not below it.
- R5: With `edge_sel_i`=1 and `level_sel_i`=1, any strobed sample strictly above the threshold fires.
- R6: With `edge_sel_i`=0 and `level_sel_i`=1, any strobed sample strictly below the threshold fires.
- R7: The first strobed sample after arming, or after a run start, never produces a crossing trigger.
- R8: While `arm_n_i`=1 nothing fires. Disarming discards the previous-sample history.
- R9: While `burst_mode_i`=0 nothing fires.
- R10: `ext_trig_ni` passes through two flip-flops. A strobe that sees the synchronised line low fires, whatever the comparator condition, provided the block is armed and in burst mode.
- R11: A trigger raises `trig_pulse_o` for exactly one cycle, starting in the cycle after the strobe edge, and at most once per run. `triggered_o` rises at the same edge and stays at 1.
- R12: `run_start_i` clears `triggered_o` at the next edge. A strobe in the same cycle as `run_start_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Conversion-done strobe, one cycle per sample |
| smp_data_i | input | 12 | Sample value |
| thresh_i | input | 8 | Trigger threshold |
| bipolar_i | input | 1 | 1: two's complement compare, 0: unsigned compare |
| edge_sel_i | input | 1 | 1: rising/above, 0: falling/below |
| level_sel_i | input | 1 | 1: level condition, 0: crossing condition |
| arm_n_i | input | 1 | Active-low arm |
| burst_mode_i | input | 1 | Burst capture mode select |
| run_start_i | input | 1 | Run restart pulse |
| ext_trig_ni | input | 1 | Asynchronous active-low external trigger |
| trig_pulse_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky triggered status |

## Verification
The trigger pulse and the status flag both become visible one edge after the strobe edge that carries the deciding sample. `triggered_o` clears one edge after a run-start cycle. An external low needs two edges through the synchroniser before any strobe can see it.

The driver pushes each expected pulse and status pair into a queue in the cycle it raises the strobe. The monitor records at each rising edge whether a strobe was present. On the following falling edge it pops the queue and compares, so every comparison falls exactly one register stage after its stimulus. The bench holds the external line for four cycles before strobing, which clears the synchroniser latency.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // condition selector: {edge_sel, level_sel}
  typedef enum logic [1:0] {
    COND_FALL  = 2'b00,
    COND_BELOW = 2'b01,
    COND_RISE  = 2'b10,
    COND_ABOVE = 2'b11
  } cond_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_res_t;
endpackage

// File: rtl/trig_compare.sv
module trig_compare
  import trig_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] ref_i,
  input  logic         signed_i,
  output cmp_res_t     res_o
);
  localparam logic [W-1:0] SignFlip = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] val_key, ref_key;

  // flipping the sign bit maps two's complement order onto unsigned order
  always_comb begin
    val_key  = signed_i ? (val_i ^ SignFlip) : val_i;
    ref_key  = signed_i ? (ref_i ^ SignFlip) : ref_i;
    res_o.gt = val_key > ref_key;
    res_o.lt = val_key < ref_key;
  end
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= 1'b1;
          else         stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= 1'b1;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_pkg::*;
#(
  parameter int unsigned SMP_W       = 12,
  parameter int unsigned CMP_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic [CMP_W-1:0] thresh_i,
  input  logic             bipolar_i,
  input  logic             edge_sel_i,
  input  logic             level_sel_i,
  input  logic             arm_n_i,
  input  logic             burst_mode_i,
  input  logic             run_start_i,
  input  logic             ext_trig_ni,
  output logic             trig_pulse_o,
  output logic             triggered_o
);
  localparam int unsigned SliceLo = SMP_W - CMP_W;

  logic [CMP_W-1:0] cur_slice;
  logic [CMP_W-1:0] prev_q;
  logic             prev_en;
  logic             prev_vld_q, prev_vld_d;
  logic             pulse_q, pulse_d;
  logic             trig_q, trig_d;
  logic             ext_sync;
  logic             armed;
  logic             hit;
  cmp_res_t         cur_res, prev_res;
  cond_e            cond;

  assign cur_slice = smp_data_i[SMP_W-1:SliceLo];
  assign armed     = !arm_n_i && burst_mode_i;
  assign cond      = cond_e'({edge_sel_i, level_sel_i});

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_trig_ni),
    .sync_o (ext_sync)
  );

  trig_compare #(.W(CMP_W)) u_cmp_cur (
    .val_i   (cur_slice),
    .ref_i   (thresh_i),
    .signed_i(bipolar_i),
    .res_o   (cur_res)
  );

  trig_compare #(.W(CMP_W)) u_cmp_prev (
    .val_i   (prev_q),
    .ref_i   (thresh_i),
    .signed_i(bipolar_i),
    .res_o   (prev_res)
  );

  // trigger condition for the current strobe
  always_comb begin
    unique case (cond)
      COND_ABOVE: hit = cur_res.gt;
      COND_BELOW: hit = cur_res.lt;
      COND_RISE:  hit = prev_vld_q && !prev_res.gt && cur_res.gt;
      default:    hit = prev_vld_q && !prev_res.lt && cur_res.lt;
    endcase
    if (!ext_sync) hit = 1'b1;
  end

  // next state
  always_comb begin
    prev_vld_d = prev_vld_q;
    pulse_d    = 1'b0;
    trig_d     = trig_q;
    prev_en    = 1'b0;
    if (run_start_i) begin
      prev_vld_d = 1'b0;
      trig_d     = 1'b0;
    end else if (!armed) begin
      prev_vld_d = 1'b0;
    end else if (smp_valid_i) begin
      prev_en    = 1'b1;
      prev_vld_d = 1'b1;
      if (!trig_q && hit) begin
        pulse_d = 1'b1;
        trig_d  = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_q <= 1'b0;
      pulse_q    <= 1'b0;
      trig_q     <= 1'b0;
    end else begin
      prev_vld_q <= prev_vld_d;
      pulse_q    <= pulse_d;
      trig_q     <= trig_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (prev_en) prev_q <= cur_slice;
  end

  assign trig_pulse_o = pulse_q;
  assign triggered_o  = trig_q;
endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_valid_i,
  input logic arm_n_i,
  input logic burst_mode_i,
  input logic run_start_i,
  input logic trig_pulse_o,
  input logic triggered_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!trig_pulse_o && !triggered_o));

  // R11
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_pulse_o |=> !trig_pulse_o);

  // R11
  pulse_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_pulse_o |-> triggered_o);

  // R11
  status_rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> trig_pulse_o);

  // R11
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !run_start_i) |=> triggered_o);

  // R12
  run_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_i |=> (!triggered_o && !trig_pulse_o));

  // R8
  disarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_n_i && !triggered_o) |=> !trig_pulse_o);

  // R9
  burst_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_mode_i && !triggered_o) |=> !trig_pulse_o);

  // R11
  pulse_from_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_pulse_o) |-> $past(smp_valid_i));
endmodule

bind trig_detect trig_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .arm_n_i     (arm_n_i),
  .burst_mode_i(burst_mode_i),
  .run_start_i (run_start_i),
  .trig_pulse_o(trig_pulse_o),
  .triggered_o (triggered_o)
);

// File: tb/trig_detect_bench.sv
`timescale 1ns/1ps
module trig_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic [7:0]  thresh;
  logic        bipolar, edge_sel, level_sel, arm_n, burst, run_start, ext_n;
  logic        trig_pulse, triggered;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic  p;
    logic  t;
    string r;
  } exp_t;
  exp_t exp_q[$];

  // bench reference model state
  logic [7:0] m_prev;
  logic       m_pv;
  logic       m_trig;
  logic       strobe_d;

  always #2 clk = ~clk;

  trig_detect u_trig_detect (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (smp_valid),
    .smp_data_i  (smp_data),
    .thresh_i    (thresh),
    .bipolar_i   (bipolar),
    .edge_sel_i  (edge_sel),
    .level_sel_i (level_sel),
    .arm_n_i     (arm_n),
    .burst_mode_i(burst),
    .run_start_i (run_start),
    .ext_trig_ni (ext_n),
    .trig_pulse_o(trig_pulse),
    .triggered_o (triggered)
  );

  task automatic check(input string req, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] key(input logic [7:0] v);
    return bipolar ? (v ^ 8'h80) : v;
  endfunction

  task automatic do_sample(input logic [11:0] d, input string req);
    logic [7:0] c;
    logic       hit;
    exp_t       e;
    @(negedge clk);
    smp_data  = d;
    smp_valid = 1'b1;
    c   = d[11:4];
    hit = 1'b0;
    if (level_sel)     hit = edge_sel ? (key(c) > key(thresh)) : (key(c) < key(thresh));
    else if (edge_sel) hit = m_pv && (key(m_prev) <= key(thresh)) && (key(c) > key(thresh));
    else               hit = m_pv && (key(m_prev) >= key(thresh)) && (key(c) < key(thresh));
    if (!ext_n) hit = 1'b1;
    e.p = 1'b0;
    if (!arm_n && burst) begin
      if (!m_trig && hit) begin
        e.p    = 1'b1;
        m_trig = 1'b1;
      end
      m_prev = c;
      m_pv   = 1'b1;
    end else begin
      m_pv = 1'b0;
    end
    e.t = m_trig;
    e.r = req;
    exp_q.push_back(e);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic set_arm(input logic a_n);
    @(negedge clk);
    arm_n = a_n;
    if (a_n) m_pv = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_run_start();
    @(negedge clk);
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    m_trig = 1'b0;
    m_pv   = 1'b0;
    check("R12", triggered, 1'b0, "triggered after run start");
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk);
    ext_n = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cond(input logic b, input logic e, input logic l, input logic [7:0] t);
    @(negedge clk);
    bipolar   = b;
    edge_sel  = e;
    level_sel = l;
    thresh    = t;
  endtask

  // monitor
  always @(posedge clk) strobe_d <= smp_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (strobe_d) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check("R11", 1'b1, 1'b0, "unexpected strobe result");
        end else begin
          e = exp_q.pop_front();
          check(e.r, trig_pulse, e.p, "trigger pulse");
          check(e.r, triggered, e.t, "triggered status");
        end
      end else begin
        check("R11", trig_pulse, 1'b0, "pulse outside strobe slot");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; thresh = '0;
    bipolar = 1'b0; edge_sel = 1'b1; level_sel = 1'b1;
    arm_n = 1'b1; burst = 1'b1; run_start = 1'b0; ext_n = 1'b1;
    m_prev = '0; m_pv = 1'b0; m_trig = 1'b0; strobe_d = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", trig_pulse, 1'b0, "pulse in reset");
    check("R1", triggered, 1'b0, "status in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", triggered, 1'b0, "status after reset");

    // R5 / R2 unsigned level above
    set_cond(1'b0, 1'b1, 1'b1, 8'h80);
    set_arm(1'b0);
    do_sample(12'h7F0, "R5");
    do_sample(12'h800, "R5");
    do_sample(12'hFF0, "R2");
    do_sample(12'hFF0, "R11");

    // R6 / R2 signed level below
    do_run_start();
    set_cond(1'b1, 1'b0, 1'b1, 8'h00);
    do_sample(12'h010, "R6");
    do_sample(12'h000, "R6");
    do_sample(12'hFF0, "R2");

    // R7 / R3 rising, unsigned
    do_run_start();
    set_cond(1'b0, 1'b1, 1'b0, 8'h40);
    do_sample(12'h500, "R7");
    do_sample(12'h600, "R3");
    do_sample(12'h300, "R3");
    do_sample(12'h400, "R3");
    do_sample(12'h500, "R3");

    // R4 / R2 falling, signed then unsigned
    do_run_start();
    set_cond(1'b1, 1'b0, 1'b0, 8'h00);
    do_sample(12'h100, "R4");
    do_sample(12'hF00, "R2");
    do_run_start();
    set_cond(1'b0, 1'b0, 1'b0, 8'h80);
    do_sample(12'h900, "R4");
    do_sample(12'hF00, "R2");
    do_sample(12'h100, "R4");

    // R8 disarmed and history discard
    do_run_start();
    set_cond(1'b0, 1'b1, 1'b1, 8'h10);
    set_arm(1'b1);
    do_sample(12'hF00, "R8");
    set_cond(1'b0, 1'b1, 1'b0, 8'h80);
    set_arm(1'b0);
    do_sample(12'h100, "R8");
    set_arm(1'b1);
    set_arm(1'b0);
    do_sample(12'hF00, "R8");

    // R9 burst off
    do_run_start();
    set_cond(1'b0, 1'b1, 1'b1, 8'h10);
    @(negedge clk); burst = 1'b0;
    do_sample(12'hF00, "R9");
    @(negedge clk); burst = 1'b1;

    // R10 external trigger
    do_run_start();
    set_cond(1'b0, 1'b0, 1'b1, 8'h00);
    do_sample(12'h500, "R10");
    set_arm(1'b1);
    set_ext(1'b0);
    do_sample(12'h500, "R10");
    set_arm(1'b0);
    do_sample(12'h500, "R10");
    set_ext(1'b1);
    do_sample(12'h500, "R11");

    // R12 strobe coinciding with run start is ignored
    set_cond(1'b0, 1'b1, 1'b1, 8'h00);
    @(negedge clk);
    run_start = 1'b1; smp_valid = 1'b1; smp_data = 12'hF00;
    begin
      exp_t e;
      e.p = 1'b0; e.t = 1'b0; e.r = "R12";
      exp_q.push_back(e);
    end
    @(negedge clk);
    run_start = 1'b0; smp_valid = 1'b0;
    m_trig = 1'b0; m_pv = 1'b0;
    do_sample(12'hF00, "R12");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule